// File: doc/BRIEF.md
# Eye-Tracking Edge Clock Controller

This block is the digital control path of an eye-tracking loop that samples every bit three times: once at a left-edge clock, once at a centre clock and once at a right-edge clock. Each cycle it receives these three samples for each of several parallel bit lanes. For each lane it checks whether the left-edge sample differs from the centre sample, and whether the right-edge sample differs from the centre sample. It combines these findings across lanes and over a short update window. At every window boundary it moves the left-edge clock and the right-edge clock by one step each, independently of one another.

The two edge-clock positions are held as thermometer words. In the left word, more ones means the left clock sits closer to the middle of the unit interval. In the right word, more ones means the right clock sits further from the middle. A clock whose window showed a transition moves inward, toward the middle of the eye. A clock whose window showed none moves outward. Over time the two clocks settle on the two edges of the open eye.

The centre-clock word is not stored. It is wired from alternating bits of the two edge words, which places the centre clock halfway between them. An eye-width figure, in interpolator steps, is reported alongside the words.

The sample input carries a valid qualifier. The block has no ready output and applies no back-pressure: every beat presented with `samp_valid` high is consumed in that cycle, and a beat with `samp_valid` low is dropped.

Top module: `eye_edge_ctrl`

## Requirements
- R1: If any lane shows left sample != centre sample on a valid beat within an update window, the left word gains one set bit at that window's end (the left clock is delayed inward).
- R2: If no valid beat in a window shows a left/centre difference on any lane, the left word loses one set bit at the window's end (the left clock is advanced outward).
- R3: If any lane shows right sample != centre sample on a valid beat within a window, the right word loses one set bit at the window's end (the right clock is advanced inward).
- R4: If no valid beat in a window shows a right/centre difference, the right word gains one set bit at the window's end (the right clock is delayed outward).
- R5: Words change only at the last cycle of each window of TICK_PERIOD = DTL_PERIOD / ETL_RATIO clock cycles counted from reset release. Beats with `samp_valid` low have no effect on the decisions.
- R6: After reset the left word is all ones, the right word is all zeros and the eye width is 0.
- R7: A step past either end of the thermometer range leaves the word unchanged (saturation at all ones and at all zeros).
- R8: Bit i of the centre word equals bit i of the left word for even i, and bit i of the right word for odd i.
- R9: The eye width equals the number of zeros in the left word plus the number of ones in the right word. It is updated on the same clock edge as the words.
- R10: Both edge words are always thermometer codes: a run of ones starting at bit 0, with only zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 1 | Qualifies the three sample vectors this cycle |
| samp_l | input | LANES | Left-edge samples, one per lane |
| samp_c | input | LANES | Centre samples, one per lane |
| samp_r | input | LANES | Right-edge samples, one per lane |
| l_word | output | WORD_W | Left-edge interpolator thermometer word |
| r_word | output | WORD_W | Right-edge interpolator thermometer word |
| c_word | output | WORD_W | Centre interpolator word built from both edge words |
| eye_width | output | $clog2(2*WORD_W+1) | Distance between the edge clocks in steps |

## Verification
The bench builds the block with four lanes, a data-tracking period of 16 and a ratio of 4, so each window is four cycles long. This makes the placement of a transition at the first and last cycle of a window directly observable. It reduces WORD_W to 7, an odd width like the default, so that both saturation ends of both words are reached within a few windows. It also keeps the interleave of the centre word covering both even and odd bit positions. Stimuli include transitions on single lanes, on both edges together, transitions caused by a set centre sample, and transitions presented with the valid qualifier low.

// File: rtl/eye_pkg.sv
package eye_pkg;

  typedef struct packed {
    logic tick;
    logic l_inward;
    logic r_inward;
  } eye_dec_t;

endpackage

// File: rtl/eye_lane_cmp.sv
module eye_lane_cmp #(
  parameter int LANES = 4
) (
  input  logic             samp_valid,
  input  logic [LANES-1:0] samp_l,
  input  logic [LANES-1:0] samp_c,
  input  logic [LANES-1:0] samp_r,
  output logic             l_any,
  output logic             r_any
);

  logic [LANES-1:0] l_diff;
  logic [LANES-1:0] r_diff;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign l_diff[g] = samp_l[g] ^ samp_c[g];
    assign r_diff[g] = samp_r[g] ^ samp_c[g];
  end

  assign l_any = samp_valid & (|l_diff);
  assign r_any = samp_valid & (|r_diff);

  always_comb begin
    if (!samp_valid) begin
      a_r5_invalid_quiet : assert (!l_any && !r_any);
    end
  end

endmodule

// File: rtl/eye_tick_filter.sv
module eye_tick_filter
  import eye_pkg::*;
#(
  parameter int TICK_PERIOD = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     l_any,
  input  logic     r_any,
  output eye_dec_t dec
);

  localparam int CNT_W = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_PERIOD - 1);

  logic [CNT_W-1:0] cnt;
  logic             l_acc;
  logic             r_acc;
  logic             tick;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      l_acc <= 1'b0;
      r_acc <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      l_acc <= 1'b0;
      r_acc <= 1'b0;
    end else begin
      cnt   <= cnt + CNT_W'(1);
      l_acc <= l_acc | l_any;
      r_acc <= r_acc | r_any;
    end
  end

  assign dec.tick     = tick;
  assign dec.l_inward = l_acc | l_any;
  assign dec.r_inward = r_acc | r_any;

  // R5: a tick is followed by TICK_PERIOD-1 quiet cycles
  a_r5_tick_spacing : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && TICK_PERIOD > 1) |=> !tick);

  // R1: a transition seen this cycle always reaches the decision
  a_r1_any_reaches : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && l_any) |-> dec.l_inward);

endmodule

// File: rtl/eye_thermo_step.sv
module eye_thermo_step #(
  parameter int   WORD_W   = 15,
  parameter logic RST_FULL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              step_up,
  output logic [WORD_W-1:0] q,
  output logic [WORD_W-1:0] q_next
);

  localparam logic [WORD_W-1:0] ALL1 = {WORD_W{1'b1}};
  localparam logic [WORD_W-1:0] ALL0 = {WORD_W{1'b0}};

  always_comb begin
    q_next = q;
    if (step_en) begin
      if (step_up) q_next = {q[WORD_W-2:0], 1'b1};
      else         q_next = {1'b0, q[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_FULL ? ALL1 : ALL0;
    else        q <= q_next;
  end

  // R10: stays a thermometer code
  a_r10_thermo : assert property (@(posedge clk) disable iff (!rst_n)
    ((q & (q + WORD_W'(1))) == ALL0));

  // R7: saturation at both ends
  a_r7_sat_full : assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && q == ALL1) |=> (q == ALL1));
  a_r7_sat_empty : assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !step_up && q == ALL0) |=> (q == ALL0));

  // R5: no movement outside a tick
  a_r5_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(q));

  // R1/R4: an upward step adds exactly one set bit when not full
  a_r1_step_up : assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && step_up && q != ALL1) |=> ($countones(q) == $countones($past(q)) + 1));

endmodule

// File: rtl/eye_edge_ctrl.sv
module eye_edge_ctrl
  import eye_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int WORD_W     = 15,
  parameter int DTL_PERIOD = 16,
  parameter int ETL_RATIO  = 4,
  localparam int TICK_PERIOD = DTL_PERIOD / ETL_RATIO,
  localparam int EW_W        = $clog2(2 * WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  input  logic [LANES-1:0]  samp_l,
  input  logic [LANES-1:0]  samp_c,
  input  logic [LANES-1:0]  samp_r,
  output logic [WORD_W-1:0] l_word,
  output logic [WORD_W-1:0] r_word,
  output logic [WORD_W-1:0] c_word,
  output logic [EW_W-1:0]   eye_width
);

  logic              l_any;
  logic              r_any;
  eye_dec_t          dec;
  logic [WORD_W-1:0] l_next;
  logic [WORD_W-1:0] r_next;
  logic [EW_W-1:0]   width_next;

  eye_lane_cmp #(.LANES(LANES)) u_cmp (
    .samp_valid (samp_valid),
    .samp_l     (samp_l),
    .samp_c     (samp_c),
    .samp_r     (samp_r),
    .l_any      (l_any),
    .r_any      (r_any)
  );

  eye_tick_filter #(.TICK_PERIOD(TICK_PERIOD)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .l_any (l_any),
    .r_any (r_any),
    .dec   (dec)
  );

  // Left: more ones = closer to the eye interior
  eye_thermo_step #(.WORD_W(WORD_W), .RST_FULL(1'b1)) u_left (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (dec.tick),
    .step_up (dec.l_inward),
    .q       (l_word),
    .q_next  (l_next)
  );

  // Right: more ones = further out; inward means fewer ones
  eye_thermo_step #(.WORD_W(WORD_W), .RST_FULL(1'b0)) u_right (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (dec.tick),
    .step_up (!dec.r_inward),
    .q       (r_word),
    .q_next  (r_next)
  );

  for (genvar g = 0; g < WORD_W; g++) begin : g_ctr
    if (g % 2 == 0) begin : g_even
      assign c_word[g] = l_word[g];
    end else begin : g_odd
      assign c_word[g] = r_word[g];
    end
  end

  always_comb begin
    width_next = '0;
    for (int i = 0; i < WORD_W; i++) begin
      width_next = width_next + EW_W'(!l_next[i]) + EW_W'(r_next[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        eye_width <= '0;
    else if (dec.tick) eye_width <= width_next;
  end

  // R9: width tracks both words
  a_r9_width : assert property (@(posedge clk) disable iff (!rst_n)
    (int'(eye_width) == WORD_W - $countones(l_word) + $countones(r_word)));

  // R3: a right-edge transition never widens the right word
  a_r3_right_in : assert property (@(posedge clk) disable iff (!rst_n)
    (dec.tick && dec.r_inward) |=> ($countones(r_word) <= $countones($past(r_word))));

endmodule

// File: tb/eye_edge_ctrl_bench.sv
module eye_edge_ctrl_bench;

  localparam int LANES = 4;
  localparam int W     = 7;
  localparam int EW_W  = $clog2(2 * W + 1);
  localparam int TP    = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             samp_valid = 1'b0;
  logic [LANES-1:0] samp_l = '0;
  logic [LANES-1:0] samp_c = '0;
  logic [LANES-1:0] samp_r = '0;
  logic [W-1:0]     l_word;
  logic [W-1:0]     r_word;
  logic [W-1:0]     c_word;
  logic [EW_W-1:0]  eye_width;

  always #10 clk = ~clk;

  eye_edge_ctrl #(.LANES(LANES), .WORD_W(W), .DTL_PERIOD(16), .ETL_RATIO(4)) u_eye_edge_ctrl (
    .clk (clk), .rst_n (rst_n), .samp_valid (samp_valid),
    .samp_l (samp_l), .samp_c (samp_c), .samp_r (samp_r),
    .l_word (l_word), .r_word (r_word), .c_word (c_word), .eye_width (eye_width)
  );

  int checks = 0;
  int fails  = 0;
  int lcnt   = W;
  int rcnt   = 0;

  // {l_hit, r_hit, cycle[1:0], lane[1:0], valid_low}
  localparam logic [6:0] VEC [0:13] = '{
    7'b0_0_00_00_0, 7'b0_0_00_00_0, 7'b1_0_11_01_0, 7'b0_1_00_10_0,
    7'b1_1_10_11_0, 7'b1_1_01_00_1, 7'b0_0_00_00_0, 7'b0_0_00_00_0,
    7'b0_0_00_00_0, 7'b0_0_00_00_0, 7'b0_0_00_00_0, 7'b0_0_00_00_0,
    7'b0_0_00_00_0, 7'b0_0_00_00_0
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [W-1:0] thermo(input int n);
    logic [W-1:0] v = '0;
    for (int i = 0; i < n; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic check_all();
    logic [W-1:0] el = thermo(lcnt);
    logic [W-1:0] er = thermo(rcnt);
    logic [W-1:0] ec;
    for (int i = 0; i < W; i++) ec[i] = (i % 2 == 0) ? el[i] : er[i];
    chk("R1/R2 left word", int'(l_word), int'(el));
    chk("R3/R4 right word", int'(r_word), int'(er));
    chk("R8 centre word", int'(c_word), int'(ec));
    chk("R9 eye width", int'(eye_width), (W - lcnt) + rcnt);
  endtask

  // At a negedge on entry; ends at the negedge after the window's tick.
  task automatic run_window(input logic [LANES-1:0] lv, input logic [LANES-1:0] cv,
                            input logic [LANES-1:0] rv, input int cyc, input logic vlow,
                            input logic l_exp, input logic r_exp);
    logic [W-1:0] l0 = l_word;
    logic [W-1:0] r0 = r_word;
    for (int k = 0; k < TP; k++) begin
      samp_valid = 1'b1;
      samp_l = '0; samp_c = '0; samp_r = '0;
      if (k == cyc) begin
        samp_l = lv; samp_c = cv; samp_r = rv;
        if (vlow) samp_valid = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      if (k == 1) begin
        chk("R5 left held mid-window", int'(l_word), int'(l0));
        chk("R5 right held mid-window", int'(r_word), int'(r0));
      end
    end
    samp_l = '0; samp_c = '0; samp_r = '0;
    if (l_exp) lcnt = (lcnt < W) ? lcnt + 1 : W;
    else       lcnt = (lcnt > 0) ? lcnt - 1 : 0;
    if (r_exp) rcnt = (rcnt > 0) ? rcnt - 1 : 0;
    else       rcnt = (rcnt < W) ? rcnt + 1 : W;
    check_all();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R6: reset state
    chk("R6 left reset", int'(l_word), int'(thermo(W)));
    chk("R6 right reset", int'(r_word), 0);
    chk("R6 width reset", int'(eye_width), 0);
    rst_n = 1'b1;

    // Vector table: R1..R5, R7, R8, R9, R10 via thermo compare
    for (int v = 0; v < 14; v++) begin
      logic [LANES-1:0] lv = '0;
      logic [LANES-1:0] rv = '0;
      logic [6:0] e = VEC[v];
      if (e[6]) lv[e[2:1]] = 1'b1;
      if (e[5]) rv[e[2:1]] = 1'b1;
      run_window(lv, '0, rv, int'(e[4:3]), e[0], e[6] & !e[0], e[5] & !e[0]);
    end
    // Now left empty and right full: R7 low/high ends held
    chk("R7 left at empty", lcnt, 0);
    chk("R7 right at full", rcnt, W);

    // R3: centre sample set with left sample set -> only a right-edge difference
    run_window(4'b0001, 4'b0001, 4'b0000, 0, 1'b0, 1'b0, 1'b1);

    // R1, R3 then R7: hits on both edges every window until saturation
    for (int n = 0; n < W + 2; n++) begin
      run_window(4'b1000, 4'b0000, 4'b0100, 3, 1'b0, 1'b1, 1'b1);
    end
    chk("R7 left at full", int'(l_word), int'(thermo(W)));
    chk("R7 right at empty", int'(r_word), 0);

    // R5: transitions only with valid low change nothing toward inward
    run_window(4'b1111, 4'b0000, 4'b1111, 2, 1'b1, 1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule